// File: doc/BRIEF.md
# Bus-to-Device Strobe Handshake Controller

This block sits between a bus master, which raises a read request or a write request, and a peripheral reached through a data transceiver. It turns each bus request into a four-phase exchange with the peripheral. It drives a strobe to the peripheral and waits for that peripheral's acknowledge. It opens the transceiver at the point the transfer direction requires, and it answers the bus with its own acknowledge. Read and write cycles open and close the transceiver at different points. In both, the strobe release and the bus acknowledge release happen in the same cycle.

The controller is clocked. Both requests and the peripheral acknowledge pass through a two-stage synchronizer before they reach the sequencer. When the block is idle and both requests are seen, the read is taken. If a bus request is withdrawn before the bus acknowledge has been given, the block raises a sticky protocol-error flag and parks with every output low until reset.

Top module: `strobe_handshake_ctrl`

## Requirements
- R1: After reset, bus acknowledge, device strobe, transceiver enable and protocol error are all low.
- R2: In a read, the device strobe rises first. The transceiver enable rises only after the synchronized device acknowledge is high. The bus acknowledge rises the cycle after the enable, while the strobe is still high.
- R3: In a read, once the read request is seen low, the transceiver enable falls. On the next cycle the device strobe and the bus acknowledge fall together.
- R4: In a write, the transceiver enable rises first and the device strobe rises on the next cycle. Once the device acknowledge is seen high, the enable falls, and on the next cycle the bus acknowledge rises.
- R5: In a write, once the write request is seen low, the device strobe and the bus acknowledge fall in the same cycle, after the enable has fallen.
- R6: From idle, no new cycle starts while the synchronized device acknowledge is still high.
- R7: If both requests are seen high while idle, a read cycle is run (device strobe before transceiver enable).
- R8: Inputs pass through two synchronizer stages. A request raised before clock edge k produces the first output change on edge k+2.
- R9: If the active request falls before the bus acknowledge has risen, the protocol-error flag rises and all three handshake outputs go low. Further input activity has no effect until reset.
- R10: Outside the error state, at most one handshake output changes per cycle. The only exception is the joint fall of the device strobe and the bus acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_req_i | input | 1 | Bus read request (asynchronous) |
| wr_req_i | input | 1 | Bus write request (asynchronous) |
| dev_ack_i | input | 1 | Peripheral acknowledge (asynchronous) |
| bus_ack_o | output | 1 | Acknowledge to the bus |
| dev_stb_o | output | 1 | Strobe to the peripheral |
| xcvr_en_o | output | 1 | Data transceiver enable |
| proto_err_o | output | 1 | Sticky protocol-violation flag |

## Verification
The handshake is exercised with a fast peripheral on a read and then on a write. The two runs separate the opposite placements of the transceiver enable in the two directions. A read with simultaneous write request shows the priority at idle. Back-to-back reads against a peripheral that is slow to drop its acknowledge show whether the idle gate really waits on the synchronized acknowledge. A request withdrawn early against a slow peripheral drives the error path, and input toggling afterwards shows the state is held until reset.

// File: rtl/shc_pkg.sv
package shc_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RD_STB,
        ST_RD_EN,
        ST_RD_ACK,
        ST_RD_DIS,
        ST_RD_RTZ,
        ST_WR_EN,
        ST_WR_STB,
        ST_WR_DIS,
        ST_WR_ACK,
        ST_WR_RTZ,
        ST_ERR
    } shc_state_e;

    typedef struct packed {
        shc_state_e state;
        logic       stb;
        logic       en;
        logic       ack;
        logic       ret;   // return-phase marker: set with bus ack, cleared at idle
        logic       err;
    } shc_regs_t;

    localparam shc_regs_t SHC_RESET = '{
        state: ST_IDLE, stb: 1'b0, en: 1'b0, ack: 1'b0, ret: 1'b0, err: 1'b0
    };

endpackage

// File: rtl/shc_sync.sv
module shc_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0][WIDTH-1:0] chain_d;
    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    always_comb begin
        chain_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= chain_d;
        end
    end

    assign sync_o = chain_q[LAST];

endmodule

// File: rtl/shc_fsm.sv
module shc_fsm
    import shc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rd_s,
    input  logic wr_s,
    input  logic ack_s,
    output logic stb_o,
    output logic en_o,
    output logic ack_o,
    output logic err_o
);
    shc_regs_t r_d;
    shc_regs_t r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            ST_IDLE: begin
                if (!ack_s) begin
                    if (rd_s) begin
                        r_d.state = ST_RD_STB;
                        r_d.stb   = 1'b1;
                    end else if (wr_s) begin
                        r_d.state = ST_WR_EN;
                        r_d.en    = 1'b1;
                    end
                end
            end
            ST_RD_STB: begin
                if (!rd_s) begin
                    r_d = SHC_RESET;
                    r_d.state = ST_ERR;
                    r_d.err   = 1'b1;
                end else if (ack_s) begin
                    r_d.state = ST_RD_EN;
                    r_d.en    = 1'b1;
                end
            end
            ST_RD_EN: begin
                if (!rd_s) begin
                    r_d = SHC_RESET;
                    r_d.state = ST_ERR;
                    r_d.err   = 1'b1;
                end else begin
                    r_d.state = ST_RD_ACK;
                    r_d.ack   = 1'b1;
                    r_d.ret   = 1'b1;
                end
            end
            ST_RD_ACK: begin
                if (!rd_s) begin
                    r_d.state = ST_RD_DIS;
                    r_d.en    = 1'b0;
                end
            end
            ST_RD_DIS: begin
                r_d.state = ST_RD_RTZ;
                r_d.stb   = 1'b0;
                r_d.ack   = 1'b0;
            end
            ST_WR_EN: begin
                if (!wr_s) begin
                    r_d = SHC_RESET;
                    r_d.state = ST_ERR;
                    r_d.err   = 1'b1;
                end else begin
                    r_d.state = ST_WR_STB;
                    r_d.stb   = 1'b1;
                end
            end
            ST_WR_STB: begin
                if (!wr_s) begin
                    r_d = SHC_RESET;
                    r_d.state = ST_ERR;
                    r_d.err   = 1'b1;
                end else if (ack_s) begin
                    r_d.state = ST_WR_DIS;
                    r_d.en    = 1'b0;
                end
            end
            ST_WR_DIS: begin
                if (!wr_s) begin
                    r_d = SHC_RESET;
                    r_d.state = ST_ERR;
                    r_d.err   = 1'b1;
                end else begin
                    r_d.state = ST_WR_ACK;
                    r_d.ack   = 1'b1;
                    r_d.ret   = 1'b1;
                end
            end
            ST_WR_ACK: begin
                if (!wr_s) begin
                    r_d.state = ST_WR_RTZ;
                    r_d.stb   = 1'b0;
                    r_d.ack   = 1'b0;
                end
            end
            ST_RD_RTZ, ST_WR_RTZ: begin
                if (!ack_s) begin
                    r_d.state = ST_IDLE;
                    r_d.ret   = 1'b0;
                end
            end
            ST_ERR: begin
                r_d = r_q;
            end
            default: begin
                r_d = SHC_RESET;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= SHC_RESET;
        end else begin
            r_q <= r_d;
        end
    end

    assign stb_o = r_q.stb;
    assign en_o  = r_q.en;
    assign ack_o = r_q.ack;
    assign err_o = r_q.err;

    logic [2:0] hs_q;
    assign hs_q = {r_q.stb, r_q.en, r_q.ack};

    AST_ACK_UNDER_STB: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.ack) |-> r_q.stb); // R2

    AST_JOINT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(r_q.ack) |-> $fell(r_q.stb)); // R3

    AST_WR_EN_LEADS: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(r_q.stb) && r_q.en) |-> $past(r_q.en)); // R4

    AST_IDLE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_IDLE && ack_s) |=> (hs_q == 3'b000)); // R6

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.err |=> (r_q.err && hs_q == 3'b000)); // R9

    AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.err
        || ($countones(hs_q ^ $past(hs_q)) <= 1)
        || ($past(hs_q) == 3'b101 && hs_q == 3'b000)); // R10

endmodule

// File: rtl/strobe_handshake_ctrl.sv
module strobe_handshake_ctrl #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_req_i,
    input  logic wr_req_i,
    input  logic dev_ack_i,
    output logic bus_ack_o,
    output logic dev_stb_o,
    output logic xcvr_en_o,
    output logic proto_err_o
);
    localparam int NUM_IN = 3;

    logic [NUM_IN-1:0] raw_in;
    logic [NUM_IN-1:0] syn_in;

    assign raw_in = {rd_req_i, wr_req_i, dev_ack_i};

    shc_sync #(
        .WIDTH  (NUM_IN),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw_in),
        .sync_o  (syn_in)
    );

    shc_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .rd_s  (syn_in[2]),
        .wr_s  (syn_in[1]),
        .ack_s (syn_in[0]),
        .stb_o (dev_stb_o),
        .en_o  (xcvr_en_o),
        .ack_o (bus_ack_o),
        .err_o (proto_err_o)
    );

endmodule

// File: tb/strobe_handshake_ctrl_bench.sv
module strobe_handshake_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rd_req_i = 1'b0;
    logic wr_req_i = 1'b0;
    logic dev_ack_i = 1'b0;
    logic bus_ack_o, dev_stb_o, xcvr_en_o, proto_err_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    strobe_handshake_ctrl u_strobe_handshake_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_req_i    (rd_req_i),
        .wr_req_i    (wr_req_i),
        .dev_ack_i   (dev_ack_i),
        .bus_ack_o   (bus_ack_o),
        .dev_stb_o   (dev_stb_o),
        .xcvr_en_o   (xcvr_en_o),
        .proto_err_o (proto_err_o)
    );

    int checks = 0;
    int failures = 0;
    string cur_req = "R1";
    int cyc = 0;
    int dev_dly = 2;
    int one_step_viol = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // ---------------- reference model (sampled at each rising edge) ----------
    logic [2:0] pipe[$] = '{3'b000, 3'b000};
    int m_mode = 0;   // 0 idle, 1 read, 2 write
    int m_step = 0;
    bit m_err  = 0;

    function automatic logic [2:0] exp_hs(int mode, int step);
        // bits: {strobe, enable, bus ack}
        if (mode == 1) begin
            case (step)
                1: return 3'b100;
                2: return 3'b110;
                3: return 3'b111;
                4: return 3'b101;
                default: return 3'b000;
            endcase
        end else if (mode == 2) begin
            case (step)
                1: return 3'b010;
                2: return 3'b110;
                3: return 3'b100;
                4: return 3'b101;
                default: return 3'b000;
            endcase
        end
        return 3'b000;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            pipe = '{3'b000, 3'b000};
            m_mode = 0; m_step = 0; m_err = 0;
        end else begin
            logic [2:0] s;
            bit r, w, a, req;
            s = pipe[0];
            void'(pipe.pop_front());
            pipe.push_back({rd_req_i, wr_req_i, dev_ack_i});
            r = s[2]; w = s[1]; a = s[0];
            if (m_err) begin
            end else if (m_mode == 0) begin
                if (!a) begin
                    if (r) begin m_mode = 1; m_step = 1; end
                    else if (w) begin m_mode = 2; m_step = 1; end
                end
            end else begin
                req = (m_mode == 1) ? r : w;
                if (!req && ((m_mode == 1) ? (m_step <= 2) : (m_step <= 3))) begin
                    m_err = 1; m_mode = 0; m_step = 0;
                end else begin
                    case (m_step)
                        1: if (m_mode == 2 || a) m_step = 2;
                        2: if (m_mode == 1 || a) m_step = 3;
                        3: if (m_mode == 2 || !req) m_step = 4;
                        4: if (m_mode == 1 || !req) m_step = 5;
                        default: if (!a) begin m_mode = 0; m_step = 0; end
                    endcase
                end
            end
        end
    end

    // ---------------- per-clock comparison and edge tracking ----------------
    logic [2:0] prev_hs = 3'b000;
    int t_stb_r = -1, t_stb_f = -1, t_en_r = -1, t_en_f = -1;
    int t_ack_r = -1, t_ack_f = -1, t_dack_r = -1, t_dack_f = -1;

    always @(negedge clk) begin
        if (rst_n) begin
            logic [2:0] hs;
            logic [2:0] ex;
            hs = {dev_stb_o, xcvr_en_o, bus_ack_o};
            ex = exp_hs(m_mode, m_step);
            chk(hs == ex, cur_req, "handshake outputs {stb,en,ack} vs model", int'(hs), int'(ex));
            chk(proto_err_o == m_err, cur_req, "error flag vs model", int'(proto_err_o), int'(m_err));
            if (!proto_err_o && $countones(hs ^ prev_hs) > 1
                && !(prev_hs == 3'b101 && hs == 3'b000))
                one_step_viol++;
            if (hs[2] && !prev_hs[2]) t_stb_r = cyc;
            if (!hs[2] && prev_hs[2]) t_stb_f = cyc;
            if (hs[1] && !prev_hs[1]) t_en_r = cyc;
            if (!hs[1] && prev_hs[1]) t_en_f = cyc;
            if (hs[0] && !prev_hs[0]) t_ack_r = cyc;
            if (!hs[0] && prev_hs[0]) t_ack_f = cyc;
            prev_hs = hs;
        end else begin
            prev_hs = 3'b000;
        end
    end

    // ---------------- peripheral responder ----------------
    int dcnt = 0;
    always @(negedge clk) begin
        if (dev_stb_o !== dev_ack_i) begin
            if (dcnt >= dev_dly) begin
                dev_ack_i = dev_stb_o;
                if (dev_ack_i) t_dack_r = cyc; else t_dack_f = cyc;
                dcnt = 0;
            end else begin
                dcnt++;
            end
        end else begin
            dcnt = 0;
        end
    end

    // ---------------- watchdog ----------------
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=0", WATCHDOG);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    task automatic bus_op(input bit rd, input bit wr, input int hold);
        rd_req_i = rd;
        wr_req_i = wr;
        while (!bus_ack_o) @(negedge clk);
        repeat (hold) @(negedge clk);
        rd_req_i = 1'b0;
        wr_req_i = 1'b0;
        while (bus_ack_o) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        rd_req_i = 1'b0;
        wr_req_i = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        @(negedge clk);
        do_reset();
        cur_req = "R1";
        chk(!bus_ack_o && !dev_stb_o && !xcvr_en_o && !proto_err_o, "R1",
            "outputs after reset", int'({bus_ack_o, dev_stb_o, xcvr_en_o, proto_err_o}), 0);

        // Read with latency probe
        cur_req = "R2";
        dev_dly = 2;
        rd_req_i = 1'b1;
        @(negedge clk);
        chk(!dev_stb_o, "R8", "strobe one edge after request", int'(dev_stb_o), 0);
        @(negedge clk);
        chk(!dev_stb_o, "R8", "strobe two edges after request", int'(dev_stb_o), 0);
        @(negedge clk);
        chk(dev_stb_o, "R8", "strobe three edges after request", int'(dev_stb_o), 1);
        bus_op(1'b1, 1'b0, 3);
        repeat (6) @(negedge clk);
        chk(t_dack_r < t_en_r, "R2", "enable after device ack", t_en_r, t_dack_r + 1);
        chk(t_stb_r < t_en_r, "R2", "strobe before enable", t_stb_r, t_en_r - 1);
        chk(t_ack_r == t_en_r + 1, "R2", "bus ack one cycle after enable", t_ack_r, t_en_r + 1);
        chk(t_en_f < t_stb_f, "R3", "enable falls before strobe", t_en_f, t_stb_f - 1);
        chk(t_stb_f == t_ack_f, "R3", "strobe and bus ack fall together", t_stb_f, t_ack_f);

        // Write
        cur_req = "R4";
        dev_dly = 3;
        bus_op(1'b0, 1'b1, 2);
        repeat (8) @(negedge clk);
        chk(t_stb_r == t_en_r + 1, "R4", "strobe one cycle after enable", t_stb_r, t_en_r + 1);
        chk(t_dack_r < t_en_f, "R4", "enable falls after device ack", t_en_f, t_dack_r + 1);
        chk(t_ack_r == t_en_f + 1, "R4", "bus ack one cycle after enable fall", t_ack_r, t_en_f + 1);
        chk(t_stb_f == t_ack_f, "R5", "strobe and bus ack fall together", t_stb_f, t_ack_f);
        chk(t_en_f < t_ack_f, "R5", "enable already low at release", t_en_f, t_ack_f - 1);

        // Both requests at once
        cur_req = "R7";
        dev_dly = 1;
        bus_op(1'b1, 1'b1, 2);
        repeat (6) @(negedge clk);
        chk(t_stb_r < t_en_r, "R7", "read ordering when both requested", t_stb_r, t_en_r - 1);

        // Slow device release, back-to-back reads
        cur_req = "R6";
        dev_dly = 8;
        bus_op(1'b1, 1'b0, 1);
        bus_op(1'b1, 1'b0, 1);
        chk(t_stb_r >= t_dack_f + 3, "R6", "new strobe waits for device ack low",
            t_stb_r, t_dack_f + 3);
        repeat (14) @(negedge clk);

        // Early request withdrawal
        cur_req = "R9";
        dev_dly = 10;
        rd_req_i = 1'b1;
        repeat (4) @(negedge clk);
        rd_req_i = 1'b0;
        repeat (4) @(negedge clk);
        chk(proto_err_o, "R9", "error flag raised", int'(proto_err_o), 1);
        wr_req_i = 1'b1;
        repeat (6) @(negedge clk);
        rd_req_i = 1'b1;
        repeat (6) @(negedge clk);
        chk(proto_err_o && !dev_stb_o && !xcvr_en_o && !bus_ack_o, "R9",
            "held in error despite requests",
            int'({proto_err_o, dev_stb_o, xcvr_en_o, bus_ack_o}), 8);
        repeat (12) @(negedge clk);
        do_reset();
        cur_req = "R1";
        chk(!proto_err_o && !dev_stb_o && !xcvr_en_o && !bus_ack_o, "R1",
            "error cleared by reset",
            int'({proto_err_o, dev_stb_o, xcvr_en_o, bus_ack_o}), 0);

        chk(one_step_viol == 0, "R10", "cycles with more than one output change",
            one_step_viol, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule